// File: doc/BRIEF.md
# Interrupt Source Detector

This block watches a bank of asynchronous interrupt request lines and keeps one raw pending bit per source. Every line is first brought into the clock domain through a flop chain, then judged by its own detection rule. Each source is independently configured as level-sensitive (with a chosen active level) or edge-sensitive (rising only, falling only, or either edge). The pending vector is meant to feed a later masking and routing stage. That stage is not part of this block.

A level-sensitive pending bit is reloaded from the qualified input on every clock, so it drops by itself once the line goes inactive. An edge-sensitive pending bit latches. It stays set until a one is presented on the matching bit of the clear mask for a single clock. The configuration and the clear mask arrive as plain vectors from the register block that owns them.

There is no data stream here, so there is no valid/ready handshake. Every pin is a plain control or status signal that is sampled on each rising clock edge.

Top module: `irq_source_detect`

## Requirements
- R1: While `rst_n` is low, `pending` is all zeros.
- R2: A source with `cfg_level`=1 and `cfg_pol`=1 is active-high. Its `pending` bit equals the input level, delayed by exactly three rising clock edges (two synchronizer stages and one register). It clears by itself when the input falls.
- R3: A source with `cfg_level`=1 and `cfg_pol`=0 is active-low. Its `pending` bit is the inverse of the input, with the same three-edge latency.
- R4: A source with `cfg_level`=0, `cfg_both`=0 and `cfg_pol`=1 sets its `pending` bit on a 0-to-1 input change and ignores 1-to-0 changes.
- R5: A source with `cfg_level`=0, `cfg_both`=0 and `cfg_pol`=0 sets its `pending` bit on a 1-to-0 input change and ignores 0-to-1 changes.
- R6: A source with `cfg_level`=0 and `cfg_both`=1 sets its `pending` bit on any change of its synchronized input, whatever `cfg_pol` holds.
- R7: An edge-mode `pending` bit stays set while its input is stable. Holding `clr_mask` bit i high across one rising edge clears bit i at that edge.
- R8: `clr_mask` has no effect on a source whose `cfg_level` bit is 1.
- R9: If a new edge and a clear hit the same edge-mode bit at the same clock edge, the bit ends up set.
- R10: After reset is released, the synchronized samples that fill the pipeline produce no edge event. A line that is already high at release does not set a rising-edge or both-edge source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_SRC | Asynchronous interrupt request lines |
| cfg_level | input | N_SRC | 1 = level-sensitive, 0 = edge-sensitive |
| cfg_both | input | N_SRC | In edge mode, 1 = fire on either edge |
| cfg_pol | input | N_SRC | Level mode: 1 = active-high. Single-edge mode: 1 = rising |
| clr_mask | input | N_SRC | One-clock clear request for edge-latched pending bits |
| pending | output | N_SRC | Raw pending bit per source |

## Verification
The bench builds the block with its default parameters: 51 sources and a two-stage synchronizer. This places the highest-numbered source, 50, and the three-edge input-to-output latency within reach of directed checks. One configuration mixes all five detection modes across low sources and the top source. This exercises them side by side, including two edge sources that see a simultaneous input change. The top source is driven high through reset to probe the warm-up window. The same source is used to collide a fresh edge with a clear at the same edge.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;

  localparam int unsigned SRC_COUNT  = 51;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    MODE_LEVEL       = 2'd0,
    MODE_EDGE_SINGLE = 2'd1,
    MODE_EDGE_BOTH   = 2'd2
  } src_mode_e;

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned N_SRC  = 51,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] din,
  output logic [N_SRC-1:0] dout
);

  // Flop chain per line; stage 0 captures the raw asynchronous input.
  logic [N_SRC-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irq_warmup.sv
module irq_warmup #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);

  // Edges are meaningful only once the chain holds real samples and the
  // previous-level register holds one of them as well.
  localparam int unsigned FILL = SYNC_STAGES + 1;
  localparam int unsigned W    = $clog2(FILL + 1);
  localparam logic [W-1:0] FILL_V = W'(FILL);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q != FILL_V) cnt_q <= cnt_q + 1'b1;
  end

  assign armed = (cnt_q == FILL_V);

endmodule

// File: rtl/irq_edge_eval.sv
module irq_edge_eval
  import irq_det_pkg::*;
#(
  parameter int unsigned N_SRC = 51
) (
  input  logic [N_SRC-1:0] smp,
  input  logic [N_SRC-1:0] prev,
  input  logic             armed,
  input  logic [N_SRC-1:0] cfg_level,
  input  logic [N_SRC-1:0] cfg_both,
  input  logic [N_SRC-1:0] cfg_pol,
  output logic [N_SRC-1:0] lvl_hit,
  output logic [N_SRC-1:0] edge_hit
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    src_mode_e mode;
    logic      edge_raw;

    always_comb begin
      if (cfg_level[i])     mode = MODE_LEVEL;
      else if (cfg_both[i]) mode = MODE_EDGE_BOTH;
      else                  mode = MODE_EDGE_SINGLE;
    end

    always_comb begin
      unique case (mode)
        MODE_EDGE_BOTH:   edge_raw = smp[i] ^ prev[i];
        MODE_EDGE_SINGLE: edge_raw = cfg_pol[i] ? (smp[i] & ~prev[i])
                                                : (~smp[i] & prev[i]);
        default:          edge_raw = 1'b0;
      endcase
    end

    // Qualified level: true when the line sits at its active level.
    assign lvl_hit[i]  = ~(smp[i] ^ cfg_pol[i]);
    assign edge_hit[i] = armed & edge_raw;
  end

endmodule

// File: rtl/irq_pending_store.sv
module irq_pending_store #(
  parameter int unsigned N_SRC = 51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] smp,
  input  logic [N_SRC-1:0] cfg_level,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic [N_SRC-1:0] lvl_hit,
  input  logic [N_SRC-1:0] edge_hit,
  output logic [N_SRC-1:0] prev_q,
  output logic [N_SRC-1:0] pending_q
);

  logic [N_SRC-1:0] clr_eff;
  logic [N_SRC-1:0] edge_next;
  logic [N_SRC-1:0] pending_d;

  // Clears only reach edge-mode bits; a fresh edge overrides a clear.
  assign clr_eff   = clr_mask & ~cfg_level;
  assign edge_next = (pending_q & ~clr_eff) | edge_hit;
  assign pending_d = (cfg_level & lvl_hit) | (~cfg_level & edge_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      pending_q <= '0;
    end else begin
      prev_q    <= smp;
      pending_q <= pending_d;
    end
  end

endmodule

// File: rtl/irq_source_detect.sv
module irq_source_detect
  import irq_det_pkg::*;
#(
  parameter int unsigned N_SRC       = SRC_COUNT,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] cfg_level,
  input  logic [N_SRC-1:0] cfg_both,
  input  logic [N_SRC-1:0] cfg_pol,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] pending
);

  logic [N_SRC-1:0] smp;
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] lvl_hit;
  logic [N_SRC-1:0] edge_hit;
  logic             armed;

  irq_sync_bank #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_in),
    .dout (smp)
  );

  irq_warmup #(.SYNC_STAGES(SYNC_STAGES)) u_warm (
    .clk  (clk),
    .rst_n(rst_n),
    .armed(armed)
  );

  irq_edge_eval #(.N_SRC(N_SRC)) u_eval (
    .smp      (smp),
    .prev     (prev_q),
    .armed    (armed),
    .cfg_level(cfg_level),
    .cfg_both (cfg_both),
    .cfg_pol  (cfg_pol),
    .lvl_hit  (lvl_hit),
    .edge_hit (edge_hit)
  );

  irq_pending_store #(.N_SRC(N_SRC)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (smp),
    .cfg_level(cfg_level),
    .clr_mask (clr_mask),
    .lvl_hit  (lvl_hit),
    .edge_hit (edge_hit),
    .prev_q   (prev_q),
    .pending_q(pending)
  );

endmodule

// File: rtl/irq_source_detect_chk.sv
module irq_source_detect_chk #(
  parameter int unsigned N_SRC = 51
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] cfg_level,
  input logic [N_SRC-1:0] cfg_pol,
  input logic [N_SRC-1:0] clr_mask,
  input logic [N_SRC-1:0] pending,
  input logic [N_SRC-1:0] smp,
  input logic [N_SRC-1:0] prev_q,
  input logic             armed
);

  // Set once a full post-reset cycle is available for $past.
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R2 and R3: level-mode bits equal the qualified sample of the previous cycle.
  assert_level_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (((pending ^ ~($past(smp) ^ $past(cfg_pol))) & $past(cfg_level)) == '0));

  // R7: an uncleared edge-mode bit never drops.
  assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((($past(pending) & ~$past(cfg_level) & ~$past(clr_mask)) & ~pending) == '0));

  // R7: a cleared edge-mode bit with a steady sample is zero afterwards.
  assert_clear_effective_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (($past(clr_mask & ~cfg_level & ~(smp ^ prev_q)) & pending) == '0));

  // R6: a new edge-mode bit needs a change between sample and previous level.
  assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((pending & ~$past(pending) & ~$past(cfg_level) & ~$past(smp ^ prev_q)) == '0));

  // R10: no edge-mode bit rises while the pipeline is still filling.
  assert_warmup_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(armed)) |-> ((pending & ~$past(pending) & ~$past(cfg_level)) == '0));

endmodule

bind irq_source_detect irq_source_detect_chk #(.N_SRC(N_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_level(cfg_level),
  .cfg_pol  (cfg_pol),
  .clr_mask (clr_mask),
  .pending  (pending),
  .smp      (smp),
  .prev_q   (prev_q),
  .armed    (armed)
);

// File: tb/test_irq_source_detect.sv
module test_irq_source_detect;

  localparam int unsigned N = 51;

  // Source roles in the bench configuration
  localparam int B_LH   = 0;   // level, active-high
  localparam int B_LL   = 1;   // level, active-low
  localparam int B_RISE = 2;   // rising edge
  localparam int B_FALL = 3;   // falling edge
  localparam int B_BOTH = 4;   // both edges
  localparam int B_LCLR = 49;  // level, active-high, clear target
  localparam int B_TOP  = 50;  // rising edge, top source

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_in, cfg_level, cfg_both, cfg_pol, clr_mask, pending;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  item_t q[$];
  event  chk_ev;
  logic [N-1:0] exp;

  always #2 clk = ~clk;

  irq_source_detect i_irq_source_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_level(cfg_level),
    .cfg_both(cfg_both), .cfg_pol(cfg_pol), .clr_mask(clr_mask), .pending(pending)
  );

  function automatic logic [N-1:0] bitv(input int k);
    logic [N-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: queue an expectation for the monitor.
  task automatic expect_now(input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    ->chk_ev;
  endtask

  task automatic clr_pulse(input logic [N-1:0] m);
    clr_mask = m;
    step(1);
    clr_mask = '0;
  endtask

  // Monitor side: pop and compare against the live output.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (pending !== it.exp) begin
          n_bad++;
          $display("FAIL %s: pending=%h expected=%h", it.tag, pending, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    cfg_level = bitv(B_LH) | bitv(B_LL) | bitv(B_LCLR);
    cfg_both  = bitv(B_BOTH);
    cfg_pol   = bitv(B_LH) | bitv(B_RISE) | bitv(B_LCLR) | bitv(B_TOP);
    clr_mask  = '0;
    irq_in    = bitv(B_RISE) | bitv(B_BOTH) | bitv(B_TOP);
    exp       = '0;

    step(3);
    expect_now("R1 reset holds pending at zero");
    rst_n = 1'b1;
    step(6);
    exp = bitv(B_LL);
    expect_now("R10 lines high at release give no edge; R3 idle active-low pending");

    irq_in[B_LH] = 1'b1;
    step(2);
    expect_now("R2 not visible after two edges");
    step(1);
    exp[B_LH] = 1'b1;
    expect_now("R2 active-high level after three edges");

    irq_in[B_LL] = 1'b1;
    step(3);
    exp[B_LL] = 1'b0;
    expect_now("R3 active-low deasserts when line high");

    irq_in[B_LH] = 1'b0;
    step(3);
    exp[B_LH] = 1'b0;
    expect_now("R2 level bit self-clears");

    irq_in[B_RISE] = 1'b0;
    step(4);
    expect_now("R4 falling change ignored by rising source");
    irq_in[B_RISE] = 1'b1;
    step(3);
    exp[B_RISE] = 1'b1;
    expect_now("R4 rising change sets");

    irq_in[B_FALL] = 1'b1;
    step(4);
    expect_now("R5 rising change ignored by falling source");
    irq_in[B_FALL] = 1'b0;
    step(3);
    exp[B_FALL] = 1'b1;
    expect_now("R5 falling change sets");

    irq_in[B_BOTH] = 1'b0;
    step(3);
    exp[B_BOTH] = 1'b1;
    expect_now("R6 both-edge source sets on fall");
    clr_pulse(bitv(B_BOTH));
    exp[B_BOTH] = 1'b0;
    expect_now("R7 single clear of both-edge bit");
    irq_in[B_BOTH] = 1'b1;
    step(3);
    exp[B_BOTH] = 1'b1;
    expect_now("R6 both-edge source sets on rise");

    step(10);
    expect_now("R7 edge bits remain latched");
    clr_pulse(bitv(B_RISE) | bitv(B_FALL) | bitv(B_BOTH));
    exp[B_RISE] = 1'b0; exp[B_FALL] = 1'b0; exp[B_BOTH] = 1'b0;
    expect_now("R7 multi-bit clear");

    irq_in[B_RISE] = 1'b0;
    irq_in[B_BOTH] = 1'b0;
    step(3);
    exp[B_BOTH] = 1'b1;
    expect_now("R4 R6 simultaneous fall: only both-edge source sets");
    clr_pulse(bitv(B_BOTH));
    exp[B_BOTH] = 1'b0;
    expect_now("R7 clear after simultaneous test");

    irq_in[B_LCLR] = 1'b1;
    step(3);
    exp[B_LCLR] = 1'b1;
    expect_now("R2 level source 49 asserted");
    clr_pulse(bitv(B_LCLR) | bitv(B_LL));
    expect_now("R8 clear ignored by level sources");
    step(2);
    expect_now("R8 level bit still follows input");

    irq_in[B_TOP] = 1'b0;
    step(4);
    expect_now("R4 top source ignores fall");
    irq_in[B_TOP] = 1'b1;
    step(2);
    clr_mask = bitv(B_TOP);
    step(1);
    clr_mask = '0;
    exp[B_TOP] = 1'b1;
    expect_now("R9 edge beats clear on top source");
    clr_pulse(bitv(B_TOP));
    exp[B_TOP] = 1'b0;
    expect_now("R7 top source cleared");

    #1;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule